// File: doc/BRIEF.md
# Message Buffer Bank with Acceptance Filtering and Transmit Scheduling

This block holds sixteen message buffers for a controller-area-network node. It sits between the frame decoder and the bit-level transmitter on one side and a CPU register port on the other. Each buffer carries a filter identifier with its format flag, a filter mask, an operating mode, a 4-bit transmit priority, a length code, a 16-bit capture time, a 64-bit payload held as two 32-bit words, and a full/ready flag.

A decoded frame arrives as one `rx_valid` pulse carrying the identifier, the format flag, the length code and the payload. The bank files it into the lowest-numbered buffer that accepts it and can take it. A plain receive buffer that already holds unread data is passed over. An overwrite buffer always takes the frame, so a group of buffers with one shared identifier, ending in an overwrite buffer, fills in index order during a burst. A free-running 16-bit timer is latched into the buffer that takes the frame, either at the start-of-frame pulse or at the end of the frame. On the transmit side, the bank offers the transmitter the most urgent ready transmit buffer on registered outputs. The transmitter can freeze that choice while it contends for the bus.

Top module: `can_mbox_bank`

## Requirements
- R1: A receive buffer accepts a frame when the format flags are equal and `(rx_id ^ buffer_id) & mask` is zero over the compared bits. Extended frames (flag 1) compare all 29 bits. Standard frames (flag 0) compare only identifier bits [28:18].
- R2: When several buffers can take a frame, it is written only to the lowest-numbered one.
- R3: A plain receive buffer (mode 1) whose full flag is set is skipped. When at least one buffer accepts the identifier but none can take the frame, `rx_drop` pulses high in the cycle after `rx_valid` and no buffer changes. When no buffer accepts the identifier, `rx_drop` stays low.
- R4: An overwrite buffer (mode 2) takes an accepted frame even when full and replaces its payload.
- R5: CPU address = {buffer index, field[2:0]}. The fields are: 0 identifier ([28:0], format flag in bit 31); 1 mask ([28:0]); 2 config (mode [1:0]: 0 off, 1 receive, 2 overwrite receive, 3 transmit; priority [11:8]; a write clears full); 3 control (write: length [7:4], bit 0 = 1 sets full; read: time [31:16], length [7:4], full [0]); 4 payload low word; 5 payload high word. Reading field 5 of a receive-mode buffer clears its full flag, and storing a frame sets it.
- R6: When `ts_at_eof` is 0, a stored frame gets the timer value sampled at the last `rx_sof` edge. When it is 1, the frame gets the timer value at the `rx_valid` edge. The timer is 0 in the first cycle after reset and counts up by one per clock.
- R7: Among full transmit-mode buffers, `tx_idx` shows the one with the numerically lowest priority, and the lowest index wins a tie. `tx_id`, `tx_ide`, `tx_dlc` and `tx_data` carry that buffer's contents, and the outputs are registered.
- R8: `tx_done` while `tx_valid` is high clears the full flag of buffer `tx_idx`, and the next choice appears on the following cycle. `tx_valid` is low when nothing is pending.
- R9: While `tx_lock` is high, the transmit outputs hold their values. After `tx_lock` falls, the choice is made again.
- R10: After reset, `tx_valid`, `rx_drop` and `cpu_rvalid` are 0. A `cpu_rd` returns `cpu_rdata` with `cpu_rvalid` high one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 7 | {buffer index, field} |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data |
| cpu_rvalid | output | 1 | Read data valid |
| ts_at_eof | input | 1 | 1: capture time at end of frame, 0: at start of frame |
| rx_sof | input | 1 | Start-of-frame pulse from the decoder |
| rx_valid | input | 1 | Decoded frame available |
| rx_id | input | 29 | Received identifier |
| rx_ide | input | 1 | Received format flag |
| rx_dlc | input | 4 | Received length code |
| rx_data | input | 64 | Received payload |
| rx_drop | output | 1 | Accepted frame had no free buffer |
| tx_lock | input | 1 | Transmitter holds the current choice |
| tx_done | input | 1 | Offered frame sent successfully |
| tx_valid | output | 1 | A transmit buffer is offered |
| tx_idx | output | 4 | Index of the offered buffer |
| tx_id | output | 29 | Identifier of the offered buffer |
| tx_ide | output | 1 | Format flag of the offered buffer |
| tx_dlc | output | 4 | Length code of the offered buffer |
| tx_data | output | 64 | Payload of the offered buffer |

## Verification
Receive dispatch is driven with a table of frames aimed at one shared-identifier chain, a lone standard buffer and a masked extended buffer. The table includes a frame whose standard identifier carries junk low bits, which separates correct standard-frame comparison from full-width comparison. Frames with the wrong format or an unmatched identifier separate "not accepted" from "accepted but dropped". Repeated frames to the chain separate skipping a full buffer from overwriting one. Transmit selection is tried with a lone request, a locked choice, a tie in priority and a chain of completions, so that order by priority, order by index and hold-while-locked each show up as a different `tx_idx` sequence.

// File: rtl/can_mbox_pkg.sv
package can_mbox_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_RX   = 2'd1,
    MODE_RXOW = 2'd2,
    MODE_TX   = 2'd3
  } mb_mode_e;

  localparam logic [2:0] FLD_ID   = 3'd0;
  localparam logic [2:0] FLD_MASK = 3'd1;
  localparam logic [2:0] FLD_CFG  = 3'd2;
  localparam logic [2:0] FLD_CTRL = 3'd3;
  localparam logic [2:0] FLD_DLO  = 3'd4;
  localparam logic [2:0] FLD_DHI  = 3'd5;
endpackage

// File: rtl/can_mbox_accept.sv
module can_mbox_accept
  import can_mbox_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int ID_W   = 29,
  parameter int STD_W  = 11
) (
  input  logic [ID_W-1:0]   rx_id,
  input  logic              rx_ide,
  input  logic [ID_W-1:0]   mb_id   [NUM_MB],
  input  logic [ID_W-1:0]   mb_mask [NUM_MB],
  input  mb_mode_e          mb_mode [NUM_MB],
  input  logic [NUM_MB-1:0] mb_ide,
  input  logic [NUM_MB-1:0] mb_full,
  output logic [NUM_MB-1:0] sel_vec,
  output logic              any_hit,
  output logic              any_sel
);
  localparam logic [ID_W-1:0] STD_KEEP = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

  logic [NUM_MB-1:0] hit;
  logic [NUM_MB-1:0] elig;

  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    logic [ID_W-1:0] eff_mask;
    logic            is_rx;
    assign eff_mask = rx_ide ? mb_mask[g] : (mb_mask[g] & STD_KEEP);
    assign is_rx    = (mb_mode[g] == MODE_RX) || (mb_mode[g] == MODE_RXOW);
    assign hit[g]   = is_rx && (mb_ide[g] == rx_ide) &&
                      (((rx_id ^ mb_id[g]) & eff_mask) == '0);
    assign elig[g]  = hit[g] && ((mb_mode[g] == MODE_RXOW) || !mb_full[g]);
  end

  always_comb begin
    sel_vec = '0;
    for (int i = NUM_MB - 1; i >= 0; i--) begin
      if (elig[i]) sel_vec = NUM_MB'(1) << i;
    end
  end

  assign any_hit = |hit;
  assign any_sel = |elig;
endmodule

// File: rtl/can_mbox_txsel.sv
module can_mbox_txsel #(
  parameter int NUM_MB = 16,
  parameter int PRIO_W = 4,
  localparam int MB_AW = $clog2(NUM_MB)
) (
  input  logic [PRIO_W-1:0] mb_prio [NUM_MB],
  input  logic [NUM_MB-1:0] pend,
  output logic [MB_AW-1:0]  best_idx,
  output logic              best_ok
);
  logic [PRIO_W-1:0] best_prio;

  always_comb begin
    best_idx  = '0;
    best_ok   = 1'b0;
    best_prio = '1;
    // scan downward so an equal priority at a lower index replaces the pick
    for (int i = NUM_MB - 1; i >= 0; i--) begin
      if (pend[i] && (!best_ok || mb_prio[i] <= best_prio)) begin
        best_idx  = MB_AW'(i);
        best_prio = mb_prio[i];
        best_ok   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_mbox_stamp.sv
module can_mbox_stamp #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sof,
  input  logic            at_eof,
  output logic [TS_W-1:0] stamp
);
  logic [TS_W-1:0] cnt;
  logic [TS_W-1:0] sof_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sof_q <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (sof) sof_q <= cnt;
    end
  end

  assign stamp = at_eof ? cnt : sof_q;
endmodule

// File: rtl/can_mbox_bank.sv
module can_mbox_bank
  import can_mbox_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int ID_W   = 29,
  parameter int STD_W  = 11,
  parameter int PRIO_W = 4,
  parameter int TS_W   = 16,
  parameter int DLC_W  = 4,
  parameter int DW     = 32,
  localparam int MB_AW  = $clog2(NUM_MB),
  localparam int ADDR_W = MB_AW + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cpu_rvalid,
  input  logic              ts_at_eof,
  input  logic              rx_sof,
  input  logic              rx_valid,
  input  logic [ID_W-1:0]   rx_id,
  input  logic              rx_ide,
  input  logic [DLC_W-1:0]  rx_dlc,
  input  logic [2*DW-1:0]   rx_data,
  output logic              rx_drop,
  input  logic              tx_lock,
  input  logic              tx_done,
  output logic              tx_valid,
  output logic [MB_AW-1:0]  tx_idx,
  output logic [ID_W-1:0]   tx_id,
  output logic              tx_ide,
  output logic [DLC_W-1:0]  tx_dlc,
  output logic [2*DW-1:0]   tx_data
);
  // per-buffer configuration and status
  logic [ID_W-1:0]   mb_id   [NUM_MB];
  logic [ID_W-1:0]   mb_mask [NUM_MB];
  mb_mode_e          mb_mode [NUM_MB];
  logic [PRIO_W-1:0] mb_prio [NUM_MB];
  logic [DLC_W-1:0]  mb_dlc  [NUM_MB];
  logic [TS_W-1:0]   mb_ts   [NUM_MB];
  logic [NUM_MB-1:0] mb_ide;
  logic [NUM_MB-1:0] mb_full;

  // payload storage, no reset so it maps onto distributed or block RAM
  logic [DW-1:0] dlo_mem [NUM_MB];
  logic [DW-1:0] dhi_mem [NUM_MB];

  logic [MB_AW-1:0] a_mb;
  logic [2:0]       a_fld;
  assign a_mb  = cpu_addr[ADDR_W-1:3];
  assign a_fld = cpu_addr[2:0];

  // receive dispatch
  logic [NUM_MB-1:0] sel_vec;
  logic [NUM_MB-1:0] rx_wr_vec;
  logic              any_hit;
  logic              any_sel;
  logic              rx_wr_any;
  logic [MB_AW-1:0]  rx_wr_idx;
  logic [TS_W-1:0]   stamp;

  can_mbox_accept #(.NUM_MB(NUM_MB), .ID_W(ID_W), .STD_W(STD_W)) u_accept (
    .rx_id   (rx_id),
    .rx_ide  (rx_ide),
    .mb_id   (mb_id),
    .mb_mask (mb_mask),
    .mb_mode (mb_mode),
    .mb_ide  (mb_ide),
    .mb_full (mb_full),
    .sel_vec (sel_vec),
    .any_hit (any_hit),
    .any_sel (any_sel)
  );

  assign rx_wr_vec = sel_vec & {NUM_MB{rx_valid}};
  assign rx_wr_any = rx_valid && any_sel;

  always_comb begin
    rx_wr_idx = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (sel_vec[i]) rx_wr_idx = MB_AW'(i);
    end
  end

  can_mbox_stamp #(.TS_W(TS_W)) u_stamp (
    .clk    (clk),
    .rst    (rst),
    .sof    (rx_sof),
    .at_eof (ts_at_eof),
    .stamp  (stamp)
  );

  // transmit selection
  logic [NUM_MB-1:0] done_mask;
  logic [NUM_MB-1:0] pend;
  logic [MB_AW-1:0]  best_idx;
  logic              best_ok;

  assign done_mask = (tx_done && tx_valid) ? (NUM_MB'(1) << tx_idx) : '0;

  always_comb begin
    for (int i = 0; i < NUM_MB; i++) begin
      pend[i] = mb_full[i] && (mb_mode[i] == MODE_TX) && !done_mask[i];
    end
  end

  can_mbox_txsel #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W)) u_txsel (
    .mb_prio  (mb_prio),
    .pend     (pend),
    .best_idx (best_idx),
    .best_ok  (best_ok)
  );

  // configuration, status and capture time
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_MB; i++) begin
        mb_id[i]   <= '0;
        mb_mask[i] <= '0;
        mb_mode[i] <= MODE_OFF;
        mb_prio[i] <= '0;
        mb_dlc[i]  <= '0;
        mb_ts[i]   <= '0;
      end
      mb_ide  <= '0;
      mb_full <= '0;
    end else begin
      if (cpu_wr) begin
        case (a_fld)
          FLD_ID: begin
            mb_id[a_mb]  <= cpu_wdata[ID_W-1:0];
            mb_ide[a_mb] <= cpu_wdata[DW-1];
          end
          FLD_MASK: mb_mask[a_mb] <= cpu_wdata[ID_W-1:0];
          FLD_CFG: begin
            mb_mode[a_mb] <= mb_mode_e'(cpu_wdata[1:0]);
            mb_prio[a_mb] <= cpu_wdata[8 +: PRIO_W];
            mb_full[a_mb] <= 1'b0;
          end
          FLD_CTRL: begin
            mb_dlc[a_mb] <= cpu_wdata[4 +: DLC_W];
            if (cpu_wdata[0]) mb_full[a_mb] <= 1'b1;
          end
          default: ;
        endcase
      end
      if (cpu_rd && a_fld == FLD_DHI &&
          (mb_mode[a_mb] == MODE_RX || mb_mode[a_mb] == MODE_RXOW))
        mb_full[a_mb] <= 1'b0;
      if (tx_done && tx_valid) mb_full[tx_idx] <= 1'b0;
      if (rx_wr_any) begin
        mb_full[rx_wr_idx] <= 1'b1;
        mb_dlc[rx_wr_idx]  <= rx_dlc;
        mb_ts[rx_wr_idx]   <= stamp;
      end
    end
  end

  // payload write port: a stored frame takes precedence over a CPU write
  always_ff @(posedge clk) begin
    if (rx_wr_any) begin
      dlo_mem[rx_wr_idx] <= rx_data[DW-1:0];
      dhi_mem[rx_wr_idx] <= rx_data[2*DW-1:DW];
    end else if (cpu_wr && a_fld == FLD_DLO) begin
      dlo_mem[a_mb] <= cpu_wdata;
    end else if (cpu_wr && a_fld == FLD_DHI) begin
      dhi_mem[a_mb] <= cpu_wdata;
    end
  end

  // registered CPU read
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
    end else begin
      cpu_rvalid <= cpu_rd;
      if (cpu_rd) begin
        case (a_fld)
          FLD_ID:   cpu_rdata <= {mb_ide[a_mb], (DW-1)'(mb_id[a_mb])};
          FLD_MASK: cpu_rdata <= DW'(mb_mask[a_mb]);
          FLD_CFG:  cpu_rdata <= DW'({mb_prio[a_mb], 6'b0, mb_mode[a_mb]});
          FLD_CTRL: cpu_rdata <= {mb_ts[a_mb], (DW-TS_W)'({mb_dlc[a_mb], 3'b0, mb_full[a_mb]})};
          FLD_DLO:  cpu_rdata <= dlo_mem[a_mb];
          FLD_DHI:  cpu_rdata <= dhi_mem[a_mb];
          default:  cpu_rdata <= '0;
        endcase
      end
    end
  end

  // receive drop flag
  always_ff @(posedge clk) begin
    if (rst) rx_drop <= 1'b0;
    else     rx_drop <= rx_valid && any_hit && !any_sel;
  end

  // registered transmit offer, frozen while the transmitter holds it
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_idx   <= '0;
      tx_id    <= '0;
      tx_ide   <= 1'b0;
      tx_dlc   <= '0;
      tx_data  <= '0;
    end else if (!tx_lock) begin
      tx_valid <= best_ok;
      tx_idx   <= best_idx;
      tx_id    <= mb_id[best_idx];
      tx_ide   <= mb_ide[best_idx];
      tx_dlc   <= mb_dlc[best_idx];
      tx_data  <= {dhi_mem[best_idx], dlo_mem[best_idx]};
    end
  end
endmodule

// File: rtl/can_mbox_chk.sv
module can_mbox_chk #(
  parameter int NUM_MB = 16,
  localparam int MB_AW = $clog2(NUM_MB)
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              rx_drop,
  input logic              cpu_rd,
  input logic              cpu_rvalid,
  input logic              tx_lock,
  input logic              tx_done,
  input logic              tx_valid,
  input logic [MB_AW-1:0]  tx_idx,
  input logic [NUM_MB-1:0] rx_wr_vec
);
  a_r2_single_dest: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rx_wr_vec));

  a_r3_drop_needs_frame: assert property (@(posedge clk) disable iff (rst)
    rx_drop |-> $past(rx_valid));

  a_r3_no_store_on_drop: assert property (@(posedge clk) disable iff (rst)
    rx_drop |-> $past(rx_wr_vec) == '0);

  a_r8_done_moves_on: assert property (@(posedge clk) disable iff (rst)
    (tx_done && tx_valid && !tx_lock) |=> (!tx_valid || tx_idx != $past(tx_idx)));

  a_r9_lock_hold: assert property (@(posedge clk) disable iff (rst)
    tx_lock |=> ($stable(tx_idx) && $stable(tx_valid)));

  a_r10_read_latency: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |-> $past(cpu_rd));
endmodule

bind can_mbox_bank can_mbox_chk #(.NUM_MB(NUM_MB)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rx_valid   (rx_valid),
  .rx_drop    (rx_drop),
  .cpu_rd     (cpu_rd),
  .cpu_rvalid (cpu_rvalid),
  .tx_lock    (tx_lock),
  .tx_done    (tx_done),
  .tx_valid   (tx_valid),
  .tx_idx     (tx_idx),
  .rx_wr_vec  (rx_wr_vec)
);

// File: tb/sim_can_mbox_bank.sv
`timescale 1ns/1ps
module sim_can_mbox_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr = 0, cpu_rd = 0;
  logic [6:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_rvalid;
  logic        ts_at_eof = 0, rx_sof = 0, rx_valid = 0, rx_ide = 0;
  logic [28:0] rx_id = '0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic        rx_drop;
  logic        tx_lock = 0, tx_done = 0, tx_valid, tx_ide;
  logic [3:0]  tx_idx, tx_dlc;
  logic [28:0] tx_id;
  logic [63:0] tx_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] tcount;
  logic [15:0] sof_t, eof_t;
  logic [31:0] rd;

  always #5 clk = ~clk;

  // bench's own view of the free-running timer (R6)
  always @(posedge clk) begin
    if (rst) tcount <= '0;
    else     tcount <= tcount + 16'd1;
  end

  can_mbox_bank u0 (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .ts_at_eof(ts_at_eof), .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_id(rx_id),
    .rx_ide(rx_ide), .rx_dlc(rx_dlc), .rx_data(rx_data), .rx_drop(rx_drop),
    .tx_lock(tx_lock), .tx_done(tx_done), .tx_valid(tx_valid), .tx_idx(tx_idx),
    .tx_id(tx_id), .tx_ide(tx_ide), .tx_dlc(tx_dlc), .tx_data(tx_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input int mb, input int fld, input logic [31:0] d);
    @(negedge clk);
    cpu_wr = 1; cpu_addr = {mb[3:0], fld[2:0]}; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic cpu_read(input int mb, input int fld, output logic [31:0] d);
    @(negedge clk);
    cpu_rd = 1; cpu_addr = {mb[3:0], fld[2:0]};
    @(negedge clk);
    cpu_rd = 0;
    d = cpu_rdata;
  endtask

  task automatic send_frame(input logic ide, input logic [28:0] id,
                            input logic [31:0] lo, output logic drop);
    @(negedge clk);
    rx_sof = 1; sof_t = tcount;
    @(negedge clk);
    rx_sof = 0;
    repeat (2) @(negedge clk);
    rx_valid = 1; rx_ide = ide; rx_id = id; rx_dlc = 4'd8;
    rx_data = {~lo, lo}; eof_t = tcount;
    @(negedge clk);
    rx_valid = 0;
    drop = rx_drop;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic        ide;
    logic [28:0] id;
    logic [31:0] lo;
    logic [3:0]  chk_mb;
    logic [31:0] chk_val;
    logic        drop;
    logic [3:0]  req;
  } rxv_t;

  localparam rxv_t TBL [9] = '{
    '{1'b0, 29'h048C0000, 32'h11110000, 4'd0, 32'h11110000, 1'b0, 4'd1}, // R1 stored in mb0
    '{1'b0, 29'h048C0000, 32'h22220000, 4'd0, 32'h11110000, 1'b1, 4'd3}, // R3 mb0 full -> drop
    '{1'b1, 29'h1ABCDE5,  32'h33330000, 4'd1, 32'h33330000, 1'b0, 4'd1}, // R1 masked extended
    '{1'b0, 29'h01540003, 32'h44440000, 4'd2, 32'h44440000, 1'b0, 4'd2}, // R2 chain head, low bits ignored
    '{1'b0, 29'h01540000, 32'h55550000, 4'd3, 32'h55550000, 1'b0, 4'd3}, // R3 full mb2 skipped
    '{1'b0, 29'h01540000, 32'h66660000, 4'd4, 32'h66660000, 1'b0, 4'd2}, // R2 chain tail
    '{1'b0, 29'h01540000, 32'h77770000, 4'd4, 32'h77770000, 1'b0, 4'd4}, // R4 overwrite
    '{1'b1, 29'h048C0000, 32'h88880000, 4'd1, 32'h33330000, 1'b0, 4'd1}, // R1 format mismatch
    '{1'b0, 29'h04900000, 32'h99990000, 4'd0, 32'h11110000, 1'b0, 4'd3}  // R3 no accept, no drop
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    check("R10 tx_valid", tx_valid, 0);
    check("R10 rx_drop", rx_drop, 0);
    check("R10 cpu_rvalid", cpu_rvalid, 0);

    // receive buffers
    cpu_write(0, 0, 32'h048C0000); cpu_write(0, 1, 32'h1FFFFFFF); cpu_write(0, 2, 32'h1);
    cpu_write(1, 0, 32'h81ABCDE0); cpu_write(1, 1, 32'h1FFFFF00); cpu_write(1, 2, 32'h1);
    for (int m = 2; m <= 4; m++) begin
      cpu_write(m, 0, 32'h01540000); cpu_write(m, 1, 32'h1FFFFFFF);
      cpu_write(m, 2, (m == 4) ? 32'h2 : 32'h1);
    end

    // R10 read latency and register readback
    @(negedge clk);
    cpu_rd = 1; cpu_addr = {4'd1, 3'd0};
    @(negedge clk);
    cpu_rd = 0;
    check("R10 rvalid", cpu_rvalid, 1);
    check("R10 id readback", cpu_rdata, 32'h81ABCDE0);

    for (int v = 0; v < 9; v++) begin
      send_frame(TBL[v].ide, TBL[v].id, TBL[v].lo, d);
      if (d !== TBL[v].drop) begin
        checks++; errors++;
        $display("FAIL R%0d vector %0d drop actual=%0b expected=%0b", TBL[v].req, v, d, TBL[v].drop);
      end else checks++;
      cpu_read(TBL[v].chk_mb, 4, rd);
      if (rd !== TBL[v].chk_val) begin
        checks++; errors++;
        $display("FAIL R%0d vector %0d data actual=%0h expected=%0h", TBL[v].req, v, rd, TBL[v].chk_val);
      end else checks++;
    end
    cpu_read(3, 4, rd);
    check("R4 mb3 untouched by overwrite", rd, 32'h55550000);

    // R5 high-word read clears full, next frame then lands in mb0
    cpu_read(0, 3, rd);
    check("R5 full set after store", {rd[7:4], rd[0]}, {4'd8, 1'b1});
    cpu_read(0, 5, rd);
    check("R5 high word", rd, 32'hEEEEFFFF);
    cpu_read(0, 3, rd);
    check("R5 full cleared by read", rd[0], 0);

    // R6 capture at start of frame
    ts_at_eof = 0;
    send_frame(1'b0, 29'h048C0000, 32'hAAAA0001, d);
    check("R5 frame accepted after read", d, 0);
    cpu_read(0, 3, rd);
    check("R6 sof stamp", rd[31:16], sof_t);
    cpu_read(0, 5, rd);
    // R6 capture at end of frame
    ts_at_eof = 1;
    send_frame(1'b0, 29'h048C0000, 32'hAAAA0002, d);
    cpu_read(0, 3, rd);
    check("R6 eof stamp", rd[31:16], eof_t);
    cpu_read(0, 4, rd);
    check("R6 payload", rd, 32'hAAAA0002);

    // transmit buffers: 8 prio5, 9 prio3, 10 prio3, 11 prio7
    cpu_write(8, 2, 32'h503); cpu_write(9, 2, 32'h303);
    cpu_write(10, 2, 32'h303); cpu_write(11, 2, 32'h703);
    cpu_write(9, 0, 32'h80012345); cpu_write(9, 4, 32'hCAFE0009);
    cpu_write(8, 3, 32'h81);
    wait_cyc(3);
    check("R7 lone request", {tx_valid, tx_idx}, {1'b1, 4'd8});
    tx_lock = 1;
    cpu_write(9, 3, 32'h81);
    wait_cyc(3);
    check("R9 held while locked", tx_idx, 8);
    tx_lock = 0;
    wait_cyc(2);
    check("R9 re-evaluated after unlock", tx_idx, 9);
    check("R7 offered id", {tx_ide, tx_id}, {1'b1, 29'h12345});
    check("R7 offered data", tx_data[31:0], 32'hCAFE0009);
    cpu_write(10, 3, 32'h81); cpu_write(11, 3, 32'h81);
    wait_cyc(2);
    check("R7 tie goes to lower index", tx_idx, 9);
    tx_done = 1; @(negedge clk); tx_done = 0; @(negedge clk);
    check("R8 next after done", tx_idx, 10);
    tx_done = 1; @(negedge clk); tx_done = 0; @(negedge clk);
    check("R7 prio5 before prio7", tx_idx, 8);
    tx_done = 1; @(negedge clk); tx_done = 0; @(negedge clk);
    check("R8 last pending", tx_idx, 11);
    tx_done = 1; @(negedge clk); tx_done = 0; @(negedge clk);
    check("R8 nothing pending", tx_valid, 0);
    cpu_read(9, 3, rd);
    check("R8 full cleared by done", rd[0], 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule